// File: doc/BRIEF.md
# Fuse Block Write Encoder

This block prepares the write image of one eight-word fuse block before it is burned. A request carries the raw write words, the words already read back from the same block, a two-bit scheme code and the block index. The encoder accepts the whole block in one beat and returns the coded image and an error flag one cycle later.

Three behaviours are supported:

- **Plain scheme.** The image passes through untouched.
- **Three-quarter scheme.** Every six data bytes gain a parity byte and a weighted population-count byte.
- **Mirror scheme.** The lower half of the block is copied into the upper half.

Requests that would write into space reserved for check bytes or copies are refused. So are requests that would write into a group that already holds burned bits. A refused request returns an all-zero image so that nothing is burned.

Both edges use valid/ready:

- **Input.** A request is taken on a clock edge where `in_valid` and `in_ready` are both high.
- **Output.** A result stays on `out_words`/`out_err` with `out_valid` high until an edge where `out_ready` is high.
- **Back-pressure.** `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure at the output therefore stalls the input directly, with no extra buffering.

Top module: `fuse_block_encoder`

## Requirements
- R1: A request accepted at a clock edge produces `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_words` and `out_err` hold steady and `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R2: With scheme code 0, or with block index 0 whatever the scheme code, the output equals the raw words and `out_err` is 0.
- R3: In scheme code 1, byte n of the block sits at bits [8n+7:8n] of the flat word vector (word k at bits [32k+31:32k]). Group g takes raw data bytes 6g..6g+5. Its coded form fills output words 2g and 2g+1: the six data bytes in bytes 8g..8g+5, the parity byte in byte 8g+6, and the weighted sum in byte 8g+7.
- R4: The parity byte is the XOR of the six data bytes. The weighted sum is the sum, modulo 256, of (i+1) times the number of set bits of data byte i, for i from 0 to 5.
- R5: In scheme code 1, a group whose six raw bytes are all zero yields zero in its two output words.
- R6: In scheme code 1, any nonzero bit in raw words 6 or 7 sets `out_err`.
- R7: In scheme code 1, a group holding nonzero raw data whose six read-back bytes (same byte positions) are not all zero sets `out_err`. Read-back data of groups with no raw data is ignored.
- R8: In scheme code 2, any nonzero bit in raw words 4 to 7 sets `out_err`. Otherwise output words k and k+4 both equal raw word k, for k from 0 to 3.
- R9: Whenever `out_err` is 1, all output words are zero.
- R10: Scheme code 3 on a nonzero block index sets `out_err`.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| raw_words | input | N_WORDS*WORD_W | Raw write image, word 0 in the low bits |
| rb_words | input | N_WORDS*WORD_W | Current read-back image of the block |
| scheme | input | 2 | 0 plain, 1 three-quarter, 2 mirror, 3 reserved |
| blk_idx | input | BLK_W | Block index; 0 forces plain |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_words | output | N_WORDS*WORD_W | Coded image |
| out_err | output | 1 | Request refused |

## Verification
The assertions assume that the source holds `raw_words`, `scheme` and `blk_idx` steady for the cycle in which `in_valid` is sampled. They also assume that `out_ready` is a plain level and not derived from `out_valid` within the same cycle. The stimulus keeps within both assumptions by changing every input only on falling edges. Scheme codes, block indices, sparsely populated groups, stray data in reserved words and occupied read-back groups are drawn from a seeded generator, so that every error path and every clean path is reached. Directed cases pin the check-byte arithmetic to known values and hold `out_ready` low for several cycles to exercise the hold rule.

// File: rtl/fenc_pkg.sv
package fenc_pkg;

  typedef enum logic [1:0] {
    SCH_PLAIN  = 2'd0,
    SCH_TQ     = 2'd1,
    SCH_MIRROR = 2'd2,
    SCH_RSVD   = 2'd3
  } scheme_e;

  function automatic logic [3:0] ones8(input logic [7:0] b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, b[i]};
    return n;
  endfunction

endpackage

// File: rtl/fenc_group_coder.sv
module fenc_group_coder #(
  parameter int DATA_BYTES = 6
) (
  input  logic [DATA_BYTES*8-1:0]     raw_grp,
  input  logic [DATA_BYTES*8-1:0]     rb_grp,
  output logic                        has_data,
  output logic                        clash,
  output logic [(DATA_BYTES+2)*8-1:0] coded
);
  import fenc_pkg::*;

  logic [7:0] par;
  logic [7:0] wsum;

  // parity byte and position-weighted popcount over the group
  always_comb begin
    par  = '0;
    wsum = '0;
    for (int i = 0; i < DATA_BYTES; i++) begin
      par  = par ^ raw_grp[8*i +: 8];
      wsum = wsum + 8'(32'(ones8(raw_grp[8*i +: 8])) * (i + 1));
    end
  end

  assign has_data = |raw_grp;
  assign clash    = |rb_grp;
  assign coded    = {wsum, par, raw_grp};

endmodule

// File: rtl/fenc_mirror_map.sv
module fenc_mirror_map #(
  parameter int TOTAL_BITS = 256
) (
  input  logic [TOTAL_BITS-1:0] raw_words,
  output logic [TOTAL_BITS-1:0] mirrored,
  output logic                  fault
);
  localparam int HALF_BITS = TOTAL_BITS / 2;

  assign fault    = |raw_words[TOTAL_BITS-1:HALF_BITS];
  assign mirrored = {raw_words[HALF_BITS-1:0], raw_words[HALF_BITS-1:0]};

endmodule

// File: rtl/fuse_block_encoder.sv
module fuse_block_encoder #(
  parameter int WORD_W         = 32,
  parameter int N_WORDS        = 8,
  parameter int GRP_DATA_BYTES = 6,
  parameter int BLK_W          = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N_WORDS*WORD_W-1:0] raw_words,
  input  logic [N_WORDS*WORD_W-1:0] rb_words,
  input  logic [1:0]                scheme,
  input  logic [BLK_W-1:0]          blk_idx,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [N_WORDS*WORD_W-1:0] out_words,
  output logic                      out_err
);
  import fenc_pkg::*;

  localparam int TOTAL_BITS  = N_WORDS * WORD_W;
  localparam int TOTAL_BYTES = TOTAL_BITS / 8;
  localparam int GRP_BYTES   = GRP_DATA_BYTES + 2;
  localparam int N_GROUPS    = TOTAL_BYTES / GRP_BYTES;
  localparam int GDATA_BITS  = GRP_DATA_BYTES * 8;
  localparam int GCODE_BITS  = GRP_BYTES * 8;
  localparam int DATA_BITS   = N_GROUPS * GDATA_BITS;

  logic [N_GROUPS-1:0]   grp_hit;
  logic [N_GROUPS-1:0]   grp_clash;
  logic [TOTAL_BITS-1:0] tq_words;
  logic                  tq_fault;
  logic [TOTAL_BITS-1:0] mir_words;
  logic                  mir_fault;
  logic [TOTAL_BITS-1:0] nxt_words;
  logic                  nxt_err;
  scheme_e               eff_sch;

  // one coder per check-byte group
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic [GCODE_BITS-1:0] coded;
    fenc_group_coder #(.DATA_BYTES(GRP_DATA_BYTES)) u_coder (
      .raw_grp  (raw_words[g*GDATA_BITS +: GDATA_BITS]),
      .rb_grp   (rb_words[g*GDATA_BITS +: GDATA_BITS]),
      .has_data (grp_hit[g]),
      .clash    (grp_clash[g]),
      .coded    (coded)
    );
    assign tq_words[g*GCODE_BITS +: GCODE_BITS] = grp_hit[g] ? coded : '0;
  end

  // pad any bits beyond the last full group
  if (N_GROUPS * GCODE_BITS < TOTAL_BITS) begin : g_pad
    assign tq_words[TOTAL_BITS-1:N_GROUPS*GCODE_BITS] = '0;
  end

  assign tq_fault = (|raw_words[TOTAL_BITS-1:DATA_BITS]) | (|(grp_hit & grp_clash));

  fenc_mirror_map #(.TOTAL_BITS(TOTAL_BITS)) u_mirror (
    .raw_words (raw_words),
    .mirrored  (mir_words),
    .fault     (mir_fault)
  );

  always_comb begin
    eff_sch = (blk_idx == '0) ? SCH_PLAIN : scheme_e'(scheme);
    unique case (eff_sch)
      SCH_PLAIN: begin
        nxt_err   = 1'b0;
        nxt_words = raw_words;
      end
      SCH_TQ: begin
        nxt_err   = tq_fault;
        nxt_words = tq_fault ? '0 : tq_words;
      end
      SCH_MIRROR: begin
        nxt_err   = mir_fault;
        nxt_words = mir_fault ? '0 : mir_words;
      end
      default: begin
        nxt_err   = 1'b1;
        nxt_words = '0;
      end
    endcase
  end

  // single output register slice
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_words <= '0;
      out_err   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_words <= nxt_words;
      out_err   <= nxt_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fenc_checker.sv
module fenc_checker #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 8,
  parameter int BLK_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [N_WORDS*WORD_W-1:0] raw_words,
  input logic [1:0]                scheme,
  input logic [BLK_W-1:0]          blk_idx,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [N_WORDS*WORD_W-1:0] out_words,
  input logic                      out_err
);
  localparam int TOTAL_BITS = N_WORDS * WORD_W;
  localparam int HALF_BITS  = TOTAL_BITS / 2;
  localparam int RES_LO     = (N_WORDS - 2) * WORD_W;

  logic acc;
  assign acc = in_valid && in_ready;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_words) && $stable(out_err)));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (blk_idx == '0 || scheme == 2'd0)) |=> (!out_err && out_words == $past(raw_words)));

  assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && blk_idx != '0 && scheme == 2'd1 && (|raw_words[TOTAL_BITS-1:RES_LO])) |=> out_err);

  assert_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && blk_idx != '0 && scheme == 2'd2) |=>
      (out_err || out_words[TOTAL_BITS-1:HALF_BITS] == out_words[HALF_BITS-1:0]));

  assert_errzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_words == '0));

  assert_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && blk_idx != '0 && scheme == 2'd3) |=> out_err);

endmodule

bind fuse_block_encoder fenc_checker #(
  .WORD_W(WORD_W), .N_WORDS(N_WORDS), .BLK_W(BLK_W)
) u_fenc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .raw_words(raw_words), .scheme(scheme), .blk_idx(blk_idx),
  .out_valid(out_valid), .out_ready(out_ready), .out_words(out_words),
  .out_err(out_err)
);

// File: tb/fuse_block_encoder_test.sv
module fuse_block_encoder_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] raw_words = '0;
  logic [255:0] rb_words = '0;
  logic [1:0]   scheme = 2'd0;
  logic [1:0]   blk_idx = 2'd0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_words;
  logic         out_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fuse_block_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .raw_words(raw_words), .rb_words(rb_words), .scheme(scheme), .blk_idx(blk_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_words(out_words), .out_err(out_err)
  );

  // reference model: returns {err, words}
  function automatic logic [256:0] model(input logic [255:0] raw, input logic [255:0] rb,
                                         input logic [1:0] sch, input logic [1:0] blk);
    logic [255:0] w;
    logic [7:0]   x;
    logic [7:0]   s;
    bit           any;
    bit           busy;
    if (blk == 2'd0 || sch == 2'd0) return {1'b0, raw};
    if (sch == 2'd3) return {1'b1, 256'd0};
    if (sch == 2'd2) begin
      if (raw[255:128] != '0) return {1'b1, 256'd0};
      return {1'b0, raw[127:0], raw[127:0]};
    end
    if (raw[255:192] != '0) return {1'b1, 256'd0};
    w = '0;
    for (int g = 0; g < 4; g++) begin
      any = 1'b0; busy = 1'b0; x = '0; s = '0;
      for (int i = 0; i < 6; i++) begin
        if (raw[8*(6*g+i) +: 8] != 8'd0) any = 1'b1;
        if (rb[8*(6*g+i) +: 8] != 8'd0) busy = 1'b1;
        x = x ^ raw[8*(6*g+i) +: 8];
        s = s + 8'((i + 1) * $countones(raw[8*(6*g+i) +: 8]));
      end
      if (any) begin
        if (busy) return {1'b1, 256'd0};
        w[64*g +: 64] = {s, x, raw[48*g +: 48]};
      end
    end
    return {1'b0, w};
  endfunction

  task automatic check(input bit ok, input string req, input logic [256:0] act, input logic [256:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [255:0] raw, input logic [255:0] rb,
                         input logic [1:0] sch, input logic [1:0] blk, input string req);
    logic [256:0] e;
    e = model(raw, rb, sch, blk);
    @(negedge clk);
    raw_words = raw; rb_words = rb; scheme = sch; blk_idx = blk;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && {out_err, out_words} == e, req, {out_err, out_words}, e);
  endtask

  function automatic logic [47:0] rnd48();
    return {16'($urandom), $urandom};
  endfunction

  initial begin
    logic [255:0] r;
    logic [255:0] b;
    logic [256:0] ea;
    logic [256:0] eb;
    string        tag;
    void'($urandom(32'd20250611));

    // R11: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11", {256'd0, out_valid}, 257'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11", {256'd0, out_valid}, 257'd0);

    // R4: all-ones group -> parity 00, sum 0xA8
    r = '0; r[47:0] = 48'hFFFF_FFFF_FFFF;
    run_txn(r, '0, 2'd1, 2'd1, "R4");
    check(out_words[63:0] == 64'hA800_FFFF_FFFF_FFFF, "R4", {1'b0, out_words}, {193'd0, 64'hA800_FFFF_FFFF_FFFF});
    // R3: bytes 01..06 in group 0 -> parity 07, sum 0x23
    r = '0; r[47:0] = 48'h0605_0403_0201;
    run_txn(r, '0, 2'd1, 2'd2, "R3");
    check(out_words == {192'd0, 64'h2307_0605_0403_0201}, "R3", {1'b0, out_words}, {193'd0, 64'h2307_0605_0403_0201});
    // R5: empty groups stay zero, only group 2 coded
    r = '0; r[96 +: 48] = 48'h0000_0000_0080;
    run_txn(r, '0, 2'd1, 2'd3, "R5");
    check(out_words[127:0] == '0 && out_words[255:192] == '0, "R5", {1'b0, out_words}, 257'd0);
    // R6: stray data in word 7
    r = '0; r[7:0] = 8'h11; r[255] = 1'b1;
    run_txn(r, '0, 2'd1, 2'd1, "R6");
    check(out_err == 1'b1, "R6", {256'd0, out_err}, 257'd1);
    // R7: occupied read-back under written group
    r = '0; r[48 +: 8] = 8'h01; b = '0; b[90 +: 1] = 1'b1;
    run_txn(r, b, 2'd1, 2'd1, "R7");
    check(out_err == 1'b1, "R7", {256'd0, out_err}, 257'd1);
    // R7: read-back under an empty group is ignored
    r = '0; r[7:0] = 8'h01; b = '0; b[150] = 1'b1;
    run_txn(r, b, 2'd1, 2'd1, "R7");
    check(out_err == 1'b0, "R7", {256'd0, out_err}, 257'd0);
    // R8: mirror with upper data -> error, and R9 zero image
    r = '0; r[0] = 1'b1; r[200] = 1'b1;
    run_txn(r, '0, 2'd2, 2'd2, "R8");
    check(out_err == 1'b1 && out_words == '0, "R9", {out_err, out_words}, {1'b1, 256'd0});
    // R10: reserved code
    run_txn({8{32'hDEAD_BEEF}}, '0, 2'd3, 2'd1, "R10");
    // R2: block 0 forces plain even with reserved code
    run_txn({8{32'h1234_5678}}, '0, 2'd3, 2'd0, "R2");

    // R1: back-pressure holds result and stalls input
    r = '0; r[31:0] = 32'hCAFE_0001;
    b = '0; b[31:0] = 32'h0000_0F0F;
    ea = model(r, '0, 2'd2, 2'd1);
    eb = model(b, '0, 2'd0, 2'd1);
    @(negedge clk);
    out_ready = 1'b0; raw_words = r; rb_words = '0; scheme = 2'd2; blk_idx = 2'd1; in_valid = 1'b1;
    @(negedge clk);
    raw_words = b; scheme = 2'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && !in_ready && {out_err, out_words} == ea, "R1", {out_err, out_words}, ea);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_err, out_words} == eb, "R1", {out_err, out_words}, eb);
    @(negedge clk);
    check(!out_valid && in_ready, "R1", {255'd0, out_valid, in_ready}, 257'd1);

    // constrained random mix
    for (int t = 0; t < 400; t++) begin
      logic [1:0] sch;
      logic [1:0] blk;
      sch = 2'($urandom_range(0, 3));
      blk = ($urandom_range(0, 7) == 0) ? 2'd0 : 2'($urandom_range(1, 3));
      r = '0; b = '0;
      for (int g = 0; g < 4; g++) begin
        if ($urandom_range(0, 1) == 1) r[48*g +: 48] = rnd48();
        if ($urandom_range(0, 6) == 0) b[48*g +: 48] = rnd48();
      end
      if ($urandom_range(0, 9) == 0) r[192 +: 64] = {$urandom, $urandom};
      if (sch == 2'd2 && $urandom_range(0, 3) != 0) r[255:128] = '0;
      if (blk == 2'd0 || sch == 2'd0) tag = "R2";
      else if (sch == 2'd1) tag = "R3";
      else if (sch == 2'd2) tag = "R8";
      else tag = "R10";
      run_txn(r, b, sch, blk, tag);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule